// File: doc/BRIEF.md
# Register-Controlled SPI Master

This block is a single-lane SPI master that software drives through seven small registers on a plain address / write-enable / data port. Software loads a transmit word and selects one slave through a one-hot select register. It then writes a control word that carries the frame length and a start bit. The block clocks the frame out most significant bit first in SPI mode 0 and samples the incoming line at the same time. When the frame ends it raises its idle flag and keeps the received bits for software to read.

The serial clock rate comes from a 16-bit divider register, and the divider can be left out at build time. A loopback switch feeds the outgoing data line back into the receiver in place of the input pin, so software can test the path without a slave attached. The select lines are active low and keep their value across frames until software rewrites the select register.

Top module: `spi_regmaster`

## Requirements
- R1: After reset, every cs_n line is high and sclk and mosi are low. The status register (address 1) reads 1 and the divider register (address 6) reads 2. The control (0), transmit (2), receive (3), select (4) and loopback (5) registers read 0. The control register reads back only its length field.
- R2: A write to address 0 launches one frame when bit 0 is 1, the length field in bits 13:8 holds N with 1 <= N <= DATA_W, and the block is idle. Status bit 0 reads 0 from the cycle after that write until the frame ends.
- R3: A start write whose length field is 0 or greater than DATA_W launches nothing, and status bit 0 stays 1.
- R4: A start write made while a frame is running is ignored. The running frame keeps its length, its timing and its received data.
- R5: For length N, mosi carries bits N-1 down to 0 of the transmit register (address 2) in that order. Each bit is valid at the rising sclk edge, and mosi changes only while sclk is low.
- R6: sclk is low whenever the block is idle (SPI mode 0). A frame of N bits lasts exactly N*E system cycles from the start write to idle, where E = max(divider, 2). In each bit, sclk is high for E - floor(E/2) cycles.
- R7: After a frame of N bits, the receive register (address 3) holds the input bits sampled at the N rising sclk edges in bits N-1 down to 0, and bits above N-1 read 0.
- R8: cs_n is the bitwise inverse of the select register (address 4, one bit per slave). It keeps that value across frames until the register is written again.
- R9: When loopback (address 5, bit 0) is 1, the receiver takes the mosi value and ignores the miso pin.
- R10: The divider register (address 6) is 16 bits wide and reads back as written. The values 0 and 1 clock at the same rate as 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Write enable for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low slave selects |

## Verification
The assertions assume that reg_we, reg_addr and reg_wdata are known and steady around every rising clock edge. They also assume that software leaves the divider register alone while a frame is running, because the phase checks would not hold through a change of rate in mid-frame. The stimulus changes the register port only on falling clock edges and writes the divider only while the block is idle. The bench's slave model changes miso only on falling sclk edges, as a mode-0 slave does, so the sampled bit is never caught while it is changing.

// File: rtl/spi_regmaster_pkg.sv
package spi_regmaster_pkg;

    localparam int unsigned BUS_W = 32;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_STATUS = 3'd1;
    localparam logic [2:0] A_TXD    = 3'd2;
    localparam logic [2:0] A_RXD    = 3'd3;
    localparam logic [2:0] A_CSEL   = 3'd4;
    localparam logic [2:0] A_LOOP   = 3'd5;
    localparam logic [2:0] A_DIV    = 3'd6;

    localparam int unsigned CTRL_GO_BIT  = 0;
    localparam int unsigned CTRL_LEN_LSB = 8;

endpackage

// File: rtl/spi_regmaster_regs.sv
module spi_regmaster_regs
    import spi_regmaster_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_CS  = 4,
    parameter int unsigned DIV_W   = 16,
    parameter bit          HAS_DIV = 1'b1,
    localparam int unsigned LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        addr_i,
    input  logic              we_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] rx_word_i,
    output logic              go_o,
    output logic [DATA_W-1:0] tx_word_o,
    output logic [LEN_W-1:0]  go_len_o,
    output logic [NUM_CS-1:0] csel_o,
    output logic              loop_o,
    output logic [DIV_W-1:0]  div_o
);

    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [LEN_W-1:0]  len;
        logic [NUM_CS-1:0] cs;
        logic              lb;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [LEN_W-1:0] wr_len;

    assign wr_len = wdata_i[CTRL_LEN_LSB +: LEN_W];

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            case (addr_i)
                A_CTRL: regs_d.len = wr_len;
                A_TXD:  regs_d.tx  = wdata_i[DATA_W-1:0];
                A_CSEL: regs_d.cs  = wdata_i[NUM_CS-1:0];
                A_LOOP: regs_d.lb  = wdata_i[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // launch only from idle with a legal length
    assign go_o = we_i && (addr_i == A_CTRL) && wdata_i[CTRL_GO_BIT] && !busy_i
                  && (wr_len != '0) && (wr_len <= LEN_W'(DATA_W));
    assign go_len_o  = wr_len;
    assign tx_word_o = regs_q.tx;
    assign csel_o    = regs_q.cs;
    assign loop_o    = regs_q.lb;

    generate
        if (HAS_DIV) begin : g_div
            logic [DIV_W-1:0] div_d, div_q;
            always_comb begin
                div_d = div_q;
                if (we_i && addr_i == A_DIV) div_d = wdata_i[DIV_W-1:0];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) div_q <= DIV_W'(2);
                else        div_q <= div_d;
            end
            assign div_o = div_q;
        end else begin : g_fixed
            assign div_o = DIV_W'(2);
        end
    endgenerate

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL:   rdata_o[CTRL_LEN_LSB +: LEN_W] = regs_q.len;
            A_STATUS: rdata_o[0] = !busy_i;
            A_TXD:    rdata_o = BUS_W'(regs_q.tx);
            A_RXD:    rdata_o = BUS_W'(rx_word_i);
            A_CSEL:   rdata_o = BUS_W'(regs_q.cs);
            A_LOOP:   rdata_o[0] = regs_q.lb;
            A_DIV:    rdata_o = BUS_W'(div_o);
            default:  rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/spi_regmaster_clkgen.sv
module spi_regmaster_clkgen #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic             last_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             rise_o,
    output logic             fall_o,
    output logic             sclk_o
);

    typedef struct packed {
        logic             on;
        logic             sclk;
        logic [DIV_W-1:0] cnt;
    } clk_t;

    clk_t st_d, st_q;
    logic [DIV_W-1:0] eff, lo_len, hi_len;

    always_comb begin
        eff    = (div_i < DIV_W'(2)) ? DIV_W'(2) : div_i;
        lo_len = eff >> 1;
        hi_len = eff - lo_len;
    end

    assign rise_o = st_q.on && !st_q.sclk && (st_q.cnt == lo_len - DIV_W'(1));
    assign fall_o = st_q.on &&  st_q.sclk && (st_q.cnt == hi_len - DIV_W'(1));

    always_comb begin
        st_d = st_q;
        if (go_i) begin
            st_d.on   = 1'b1;
            st_d.sclk = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.on) begin
            if (rise_o) begin
                st_d.sclk = 1'b1;
                st_d.cnt  = '0;
            end else if (fall_o) begin
                st_d.sclk = 1'b0;
                st_d.cnt  = '0;
                if (last_i) st_d.on = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk_o = st_q.sclk;

endmodule

// File: rtl/spi_regmaster_engine.sv
module spi_regmaster_engine #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LEN_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DATA_W-1:0] tx_word_i,
    input  logic              loop_i,
    input  logic              miso_i,
    input  logic              rise_i,
    input  logic              fall_i,
    output logic              busy_o,
    output logic              last_o,
    output logic              mosi_o,
    output logic [DATA_W-1:0] rx_word_o
);

    typedef struct packed {
        logic              busy;
        logic [LEN_W-1:0]  left;
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx_sh;
        logic [DATA_W-1:0] rx_out;
    } eng_t;

    eng_t st_d, st_q;
    logic in_bit;

    assign mosi_o = st_q.busy && st_q.tx_sh[DATA_W-1];
    assign in_bit = loop_i ? mosi_o : miso_i;
    assign last_o = (st_q.left == LEN_W'(1));

    always_comb begin
        st_d = st_q;
        if (go_i) begin
            st_d.busy  = 1'b1;
            st_d.left  = len_i;
            st_d.tx_sh = tx_word_i << (DATA_W - int'(len_i));
            st_d.rx_sh = '0;
        end else if (st_q.busy) begin
            if (rise_i) begin
                st_d.rx_sh = {st_q.rx_sh[DATA_W-2:0], in_bit};
            end else if (fall_i) begin
                if (last_o) begin
                    st_d.busy   = 1'b0;
                    st_d.rx_out = st_q.rx_sh;
                end else begin
                    st_d.left  = st_q.left - LEN_W'(1);
                    st_d.tx_sh = st_q.tx_sh << 1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o    = st_q.busy;
    assign rx_word_o = st_q.rx_out;

endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
    import spi_regmaster_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_CS  = 4,
    parameter int unsigned DIV_W   = 16,
    parameter bit          HAS_DIV = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);

    localparam int unsigned LEN_W = $clog2(DATA_W + 1);

    logic              eng_busy, eng_last, go, rise, fall, loop_en;
    logic [DATA_W-1:0] tx_word, rx_word;
    logic [LEN_W-1:0]  go_len;
    logic [NUM_CS-1:0] csel;
    logic [DIV_W-1:0]  div_val;

    spi_regmaster_regs #(
        .DATA_W(DATA_W), .NUM_CS(NUM_CS), .DIV_W(DIV_W), .HAS_DIV(HAS_DIV)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .addr_i(reg_addr), .we_i(reg_we), .wdata_i(reg_wdata), .rdata_o(reg_rdata),
        .busy_i(eng_busy), .rx_word_i(rx_word),
        .go_o(go), .tx_word_o(tx_word), .go_len_o(go_len),
        .csel_o(csel), .loop_o(loop_en), .div_o(div_val)
    );

    spi_regmaster_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n),
        .go_i(go), .last_i(eng_last), .div_i(div_val),
        .rise_o(rise), .fall_o(fall), .sclk_o(sclk)
    );

    spi_regmaster_engine #(.DATA_W(DATA_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .go_i(go), .len_i(go_len), .tx_word_i(tx_word),
        .loop_i(loop_en), .miso_i(miso),
        .rise_i(rise), .fall_i(fall),
        .busy_o(eng_busy), .last_o(eng_last), .mosi_o(mosi), .rx_word_o(rx_word)
    );

    assign cs_n = ~csel;

endmodule

// File: rtl/spi_regmaster_chk.sv
module spi_regmaster_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NUM_CS = 4,
    localparam int unsigned LEN_W = $clog2(DATA_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        reg_addr,
    input logic              reg_we,
    input logic [31:0]       reg_wdata,
    input logic              sclk,
    input logic              mosi,
    input logic [NUM_CS-1:0] cs_n,
    input logic              eng_busy
);

    logic             start_ok;
    logic [LEN_W-1:0] wlen;
    logic             cs_wr;

    assign wlen     = reg_wdata[8 +: LEN_W];
    assign start_ok = reg_we && (reg_addr == 3'd0) && reg_wdata[0] && !eng_busy
                      && (wlen != '0) && (wlen <= LEN_W'(DATA_W));
    assign cs_wr    = reg_we && (reg_addr == 3'd4);

    AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !sclk); // R6

    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> eng_busy); // R2

    AST_BAD_LEN_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd0 && !eng_busy && (wlen == '0 || wlen > LEN_W'(DATA_W)))
        |=> !eng_busy); // R3

    AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi)); // R5

    AST_CS_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_wr |=> (cs_n == ~$past(reg_wdata[NUM_CS-1:0]))); // R8

    AST_CS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_wr |=> $stable(cs_n)); // R8

endmodule

bind spi_regmaster spi_regmaster_chk #(.DATA_W(DATA_W), .NUM_CS(NUM_CS)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .eng_busy(eng_busy)
);

// File: tb/spi_regmaster_bench.sv
module spi_regmaster_bench;

    localparam int NCS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = 3'd1;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi, miso;
    logic [NCS-1:0] cs_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    spi_regmaster #(.DATA_W(32), .NUM_CS(NCS), .DIV_W(16), .HAS_DIV(1'b1)) u_spi_regmaster (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    // mode-0 slave: presents next bit after each falling edge, captures mosi on rising
    logic [31:0] s_sh = '0;
    logic [31:0] cap = '0;
    int          cap_n = 0;
    assign miso = s_sh[31];
    always @(negedge sclk) s_sh <= s_sh << 1;
    always @(posedge sclk) begin
        cap   <= {cap[30:0], mosi};
        cap_n <= cap_n + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 3'd1;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    function automatic logic [31:0] low_mask(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    endfunction

    task automatic run_frame(input int len, input logic [31:0] tx, input logic [31:0] sword,
                             input int eff, input bit lb, input bit poke, input string tag);
        logic [31:0] v;
        int cyc, hi;
        reg_write(3'd2, tx);
        s_sh = sword << (32 - len);
        cap = '0;
        cap_n = 0;
        reg_write(3'd0, (32'(len) << 8) | 32'd1);
        reg_read(3'd1, v);
        check({"R2 busy after start ", tag}, v, 32'd0);
        cyc = 0; hi = 0;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 2) begin
                reg_addr = 3'd0; reg_we = 1'b1; reg_wdata = (32'd5 << 8) | 32'd1;
            end else if (poke && cyc == 3) begin
                reg_we = 1'b0; reg_addr = 3'd1;
            end
            #1;
            if (sclk) hi++;
            if (reg_addr == 3'd1 && reg_rdata[0]) break;
            if (cyc > 20000) break;
        end
        check({poke ? "R4 duration " : "R6 duration ", tag}, 32'(cyc), 32'(len * eff));
        check({"R6 high phase ", tag}, 32'(hi), 32'(len * (eff - eff / 2)));
        check({"R5 mosi bits ", tag}, cap, tx & low_mask(len));
        check({"R5 bit count ", tag}, 32'(cap_n), 32'(len));
        reg_read(3'd3, v);
        check({lb ? "R9 loopback rx " : (poke ? "R4 rx " : "R7 rx "), tag}, v,
              (lb ? tx : sword) & low_mask(len));
        reg_addr = 3'd1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 cs_n", 32'(cs_n), 32'hF);
        check("R1 sclk", 32'(sclk), 32'd0);
        check("R1 mosi", 32'(mosi), 32'd0);
        reg_read(3'd1, v); check("R1 status", v, 32'd1);
        reg_read(3'd6, v); check("R1 divider", v, 32'd2);
        for (int a = 0; a < 6; a++) begin
            if (a != 1) begin
                reg_read(3'(a), v); check("R1 register zero", v, 32'd0);
            end
        end

        // R8: select slave 2
        reg_write(3'd4, 32'h4);
        check("R8 cs_n after write", 32'(cs_n), 32'hB);

        // R5 R6 R7: sweep every length, divider 2
        for (int n = 1; n <= 32; n++) begin
            run_frame(n, 32'hA5C3_1E97 ^ (32'(n) * 32'h0101_0101),
                      32'h5A3C_E169 + 32'(n) * 32'd7, 2, 1'b0, 1'b0, "len sweep");
        end
        check("R8 cs_n kept across frames", 32'(cs_n), 32'hB);

        // R10: divider sweep incl. 0 and 1
        for (int d = 0; d < 8; d++) begin
            reg_write(3'd6, 32'(d));
            reg_read(3'd6, v); check("R10 divider readback", v, 32'(d));
            run_frame(8, 32'h0000_00C6 + 32'(d), 32'h0000_0039 ^ 32'(d * 5),
                      (d < 2) ? 2 : d, 1'b0, 1'b0, "R10 divider sweep");
        end
        reg_write(3'd6, 32'd2);

        // R9: loopback ignores miso
        reg_write(3'd5, 32'd1);
        reg_read(3'd5, v); check("R9 loopback readback", v, 32'd1);
        for (int n = 1; n <= 32; n += 3) begin
            run_frame(n, 32'h1357_9BDF ^ (32'(n) << 3), ~(32'h1357_9BDF ^ (32'(n) << 3)),
                      2, 1'b1, 1'b0, "loopback");
        end
        reg_write(3'd5, 32'd0);

        // R4: start during a frame is ignored
        reg_write(3'd6, 32'd3);
        run_frame(12, 32'h0000_0B5E, 32'h0000_0A71, 3, 1'b0, 1'b1, "restart ignored");
        reg_write(3'd6, 32'd2);

        // R3: illegal lengths do nothing
        reg_write(3'd0, 32'd1);
        reg_read(3'd1, v); check("R3 length 0 ignored", v, 32'd1);
        check("R3 sclk low after length 0", 32'(sclk), 32'd0);
        reg_write(3'd0, (32'd40 << 8) | 32'd1);
        reg_read(3'd1, v); check("R3 length 40 ignored", v, 32'd1);
        reg_write(3'd0, (32'd33 << 8) | 32'd1);
        reg_read(3'd1, v); check("R3 length 33 ignored", v, 32'd1);

        // R8: deselect
        reg_write(3'd4, 32'd0);
        check("R8 cs_n released", 32'(cs_n), 32'hF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule